// File: doc/BRIEF.md
# Mod-3 Residue Checked Adder

This block adds two unsigned operands and checks every addition as it happens. The binary sum keeps its carry-out, so an 8-bit pair gives a 9-bit result. A second path, separate from the adder, works only on remainders. It reduces each operand modulo 3 and adds the two remainders modulo 3 to predict the remainder of the result. It then reduces the adder's actual output modulo 3 and compares it with that prediction. If the two differ, the error flag rises.

A fault-injection mask is XORed into the sum before it is registered and before its remainder is taken. A test environment can use it to corrupt the result on purpose and watch the checker react. The registered sum and error flag both update on the clock edge that accepts an operand pair, so each result appears one cycle after it was presented. Results can be accepted on every cycle.

Top module: `residue_checked_adder`

## Requirements
- R1: While reset is asserted, and right after it is released, sumOut is 0, errFlag is 0 and outValid is 0.
- R2: When inValid is 1 at a rising clock edge, then after that edge outValid is 1 and sumOut equals (opA + opB) XOR faultMask. The sum is 9 bits wide and bit 8 holds the carry-out.
- R3: With faultMask equal to 0, errFlag is 0 for every operand pair. This includes 0+0, 255+255 and pairs that produce a carry.
- R4: A faultMask with exactly one bit set, at any of the 9 positions, always sets errFlag to 1 for the corrupted result.
- R5: errFlag is 1 exactly when (sumOut mod 3) differs from ((opA mod 3 + opB mod 3) mod 3). A mask that changes the sum by a multiple of 3 goes undetected. For example, 4 + 0 with mask 9'b000000011 gives sumOut 7 and errFlag 0.
- R6: When inValid is 0 at a rising edge, outValid is 0 after that edge, and sumOut and errFlag keep their values. opA, opB and faultMask have no effect in that case.
- R7: Operand pairs presented on consecutive cycles each give their own result on consecutive cycles, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Accept the operand pair at this edge |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| faultMask | input | 9 | Pattern XORed into the sum for fault injection |
| outValid | output | 1 | A new result was captured on the last edge |
| sumOut | output | 9 | Registered sum, possibly corrupted by faultMask |
| errFlag | output | 1 | Registered residue mismatch for sumOut |

## Verification
The properties that relate a result to its operands assume inValid is held low while reset is asserted. They only look at attempts where reset is already released. The stimulus keeps inValid at 0 throughout both reset pulses, including the one in the middle of the run, and starts presenting operands only after release. The checks also assume that faultMask is the only source of corruption. For that reason the stimulus sweeps every single-bit mask, adds multi-bit masks whose effect is and is not a multiple of 3, and changes the operands and mask freely during idle cycles to show they are ignored.

// File: rtl/res3_pkg.sv
package res3_pkg;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic loadResult;
  } ctrlStrobe_t;

  // Width of a remainder modulo 3.
  localparam int RES_W = 2;

endpackage

// File: rtl/residue3_fold.sv
// Reduces a vector to its remainder modulo 3.
// Bit weights alternate: even positions count 1 and odd positions count 2.
// The weighted count is folded again until it is small, and a final
// subtraction brings it into the range 0..2.
module residue3_fold #(
  parameter int IN_W = 9
) (
  input  logic [IN_W-1:0]            value,
  output logic [res3_pkg::RES_W-1:0] residue
);

  localparam int ACC_W = $clog2(2 * IN_W + 1) + 1;
  localparam int FOLDS = $clog2(ACC_W) + 2;

  logic [ACC_W-1:0] accum;
  logic [ACC_W-1:0] folded;

  always_comb begin
    // First pass over the input vector.
    accum = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (i % 2 == 0) accum = accum + ACC_W'(value[i]);
      else            accum = accum + ACC_W'({value[i], 1'b0});
    end

    // Fold the count again until it is at most 4.
    folded = '0;
    for (int f = 0; f < FOLDS; f++) begin
      folded = '0;
      for (int i = 0; i < ACC_W; i++) begin
        if (i % 2 == 0) folded = folded + ACC_W'(accum[i]);
        else            folded = folded + ACC_W'({accum[i], 1'b0});
      end
      accum = folded;
    end

    // Final step into the range 0..2.
    if (accum >= ACC_W'(3)) residue = res3_pkg::RES_W'(accum - ACC_W'(3));
    else                    residue = res3_pkg::RES_W'(accum);
  end

endmodule

// File: rtl/rca_ctrl.sv
// Control: turns the input handshake into a load strobe and produces the
// output-valid register.
module rca_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output res3_pkg::ctrlStrobe_t strobes,
  output logic                  outValid
);

  always_comb begin
    strobes.loadResult = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/rca_datapath.sv
// Datapath: the binary adder, fault injection, the residue predictor, the
// residue of the actual result, the comparison, and the output registers.
module rca_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  res3_pkg::ctrlStrobe_t strobes,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  input  logic [DATA_W:0]       faultMask,
  output logic [DATA_W:0]       sumOut,
  output logic                  errFlag
);

  localparam int SUM_W  = DATA_W + 1;
  localparam int RW     = res3_pkg::RES_W;
  localparam int N_OPS  = 2;
  localparam int PAIR_W = RW + 1;

  logic [SUM_W-1:0]  rawSum;
  logic [SUM_W-1:0]  checkedSum;
  logic [DATA_W-1:0] opArr [N_OPS];
  logic [RW-1:0]     opRes [N_OPS];
  logic [RW-1:0]     sumRes;
  logic [PAIR_W-1:0] pairSum;
  logic [RW-1:0]     predRes;
  logic              mismatch;

  // Main adder. The carry-out is kept as the top bit of the result.
  always_comb begin
    rawSum     = {1'b0, opA} + {1'b0, opB};
    checkedSum = rawSum ^ faultMask;
  end

  assign opArr[0] = opA;
  assign opArr[1] = opB;

  // One remainder unit per operand.
  for (genvar g = 0; g < N_OPS; g++) begin : g_opRes
    residue3_fold #(.IN_W(DATA_W)) u_fold (
      .value  (opArr[g]),
      .residue(opRes[g])
    );
  end

  // Remainder of the result as it leaves the adder (after injection).
  residue3_fold #(.IN_W(SUM_W)) u_sumFold (
    .value  (checkedSum),
    .residue(sumRes)
  );

  // Predicted remainder: add the operand remainders and reduce modulo 3.
  always_comb begin
    pairSum = {1'b0, opRes[0]} + {1'b0, opRes[1]};
    if (pairSum >= PAIR_W'(3)) predRes = RW'(pairSum - PAIR_W'(3));
    else                       predRes = RW'(pairSum);
    mismatch = (predRes != sumRes);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumOut  <= '0;
      errFlag <= 1'b0;
    end else if (strobes.loadResult) begin
      sumOut  <= checkedSum;
      errFlag <= mismatch;
    end
  end

endmodule

// File: rtl/residue_checked_adder.sv
// Top level: connects the control module to the datapath.
module residue_checked_adder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W:0]   faultMask,
  output logic              outValid,
  output logic [DATA_W:0]   sumOut,
  output logic              errFlag
);

  res3_pkg::ctrlStrobe_t strobes;

  rca_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  rca_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .faultMask(faultMask),
    .sumOut   (sumOut),
    .errFlag  (errFlag)
  );

endmodule

// File: rtl/rca_checker.sv
// Properties for the top module, attached with a bind statement.
module rca_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W:0]   faultMask,
  input logic              outValid,
  input logic [DATA_W:0]   sumOut,
  input logic              errFlag
);

  localparam int SW = DATA_W + 1;

  logic [SW-1:0] trueSum;
  logic [SW-1:0] seenSum;
  logic          expErr;

  // Reference values computed directly with the modulo operator.
  always_comb begin
    trueSum = {1'b0, opA} + {1'b0, opB};
    seenSum = trueSum ^ faultMask;
    expErr  = (seenSum % SW'(3)) != (trueSum % SW'(3));
  end

  // R2: a captured result carries the masked sum, and outValid is raised.
  a_r2_sum_captured: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid |=> outValid &&
      sumOut == (({1'b0, $past(opA)} + {1'b0, $past(opB)}) ^ $past(faultMask)));

  // R3: no injected corruption means no error.
  a_r3_clean_no_error: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid && faultMask == '0 |=> !errFlag);

  // R4: any single-bit corruption is flagged.
  a_r4_single_bit_flagged: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid && $countones(faultMask) == 1 |=> errFlag);

  // R5: the flag matches the modulo-3 comparison.
  a_r5_flag_matches_residue: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid |=> errFlag == $past(expErr));

  // R6: idle cycles keep the outputs and clear outValid.
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !inValid |=> !outValid && $stable(sumOut) && $stable(errFlag));

endmodule

bind residue_checked_adder rca_checker #(.DATA_W(DATA_W)) u_rcaChecker (.*);

// File: tb/test_residue_checked_adder.sv
module test_residue_checked_adder;

  localparam int DW = 8;
  localparam int SW = DW + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic [SW-1:0] faultMask = '0;
  logic          outValid;
  logic [SW-1:0] sumOut;
  logic          errFlag;

  always #5 clk = ~clk;

  residue_checked_adder #(.DATA_W(DW)) i_residue_checked_adder (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .faultMask(faultMask),
    .outValid (outValid),
    .sumOut   (sumOut),
    .errFlag  (errFlag)
  );

  typedef struct {
    logic [SW-1:0] sum;
    logic          err;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared   = 0;
  int mismatched = 0;
  logic [SW-1:0] lastSum = '0;
  logic          lastErr = 1'b0;

  task automatic checkVal(input string req, input logic [SW-1:0] act,
                          input logic [SW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: present one pair and push the expected result. Called at negedge.
  task automatic sendPair(input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [SW-1:0] m, input string tag);
    expItem_t it;
    logic [SW-1:0] s;
    s = {1'b0, a} + {1'b0, b};
    it.sum = s ^ m;
    it.err = ((s ^ m) % SW'(3)) != (s % SW'(3));
    it.tag = tag;
    lastSum = it.sum;
    lastErr = it.err;
    opA = a; opB = b; faultMask = m; inValid = 1'b1;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // Idle cycles with changing inputs that must be ignored.
  task automatic idleCycles(input int n);
    for (int k = 0; k < n; k++) begin
      inValid = 1'b0;
      opA = DW'($urandom); opB = DW'($urandom); faultMask = SW'($urandom);
      @(negedge clk);
    end
  endtask

  // Monitor: pop and compare results as they come out.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checkVal("R6 outValid with nothing pending", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        checkVal({it.tag, " sum"}, sumOut, it.sum);
        checkVal({it.tag, " errFlag"}, SW'(errFlag), SW'(it.err));
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: state while reset is asserted.
    repeat (3) @(negedge clk);
    checkVal("R1 sumOut in reset", sumOut, 0);
    checkVal("R1 errFlag in reset", SW'(errFlag), 0);
    checkVal("R1 outValid in reset", SW'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 outValid after release", SW'(outValid), 0);

    // R2/R3: clean sums, extremes and carry.
    sendPair(8'd0,   8'd0,   '0, "R3 zero");
    sendPair(8'd255, 8'd255, '0, "R3 max+max");
    sendPair(8'd255, 8'd1,   '0, "R2 carry");
    sendPair(8'd170, 8'd85,  '0, "R2 alternating");
    sendPair(8'd100, 8'd27,  '0, "R3 plain");
    idleCycles(2);

    // R6: the outputs hold across idle cycles with changing inputs.
    idleCycles(3);
    checkVal("R6 sum held", sumOut, lastSum);
    checkVal("R6 err held", SW'(errFlag), SW'(lastErr));
    checkVal("R6 outValid low", SW'(outValid), 0);

    // R4: every single-bit mask position.
    for (int p = 0; p < SW; p++) sendPair(8'hA5, 8'h3C, SW'(1) << p, "R4 single bit");
    idleCycles(2);

    // R5: a change that is a multiple of 3 is missed; other multi-bit changes are caught.
    sendPair(8'd4, 8'd0, 9'b000000011, "R5 undetected +3");
    sendPair(8'd5, 8'd0, 9'b000000011, "R5 detected");
    sendPair(8'd0, 8'd0, 9'b000001111, "R5 plus 15");
    sendPair(8'd200, 8'd100, 9'b110000000, "R5 upper bits");
    idleCycles(1);
    checkVal("R6 held after flagged result", SW'(errFlag), SW'(lastErr));

    // R7: a back-to-back stream with occasional corruption.
    for (int k = 0; k < 60; k++) begin
      logic [SW-1:0] m;
      m = ($urandom % 3 == 0) ? SW'($urandom) : '0;
      sendPair(DW'($urandom), DW'($urandom), m, "R7 stream");
    end
    idleCycles(3);
    checkVal("R7 queue drained", SW'(expQ.size()), 0);

    // R1: a reset in the middle of the run clears a nonzero result.
    sendPair(8'd200, 8'd200, 9'b000000001, "R2 before reset");
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkVal("R1 sumOut after mid reset", sumOut, 0);
    checkVal("R1 errFlag after mid reset", SW'(errFlag), 0);
    checkVal("R1 outValid after mid reset", SW'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule